// File: doc/BRIEF.md
# Serial Audio Slave Receiver

This block takes in a three-wire serial audio stream as a slave. An external master drives the bit clock and the word-select line, and the block never produces either one. The block brings the bit clock, word select and serial data into the system clock domain with synchronizers. It samples one data bit on each rising edge of the bit clock. It finds slot boundaries from word-select transitions and collects the data bits of each slot into 16-bit words. The position of those bits in the slot depends on the selected framing standard, the data length and the channel length.

Each finished word goes into a single receive buffer, which the host reads through a data-read strobe. A 16-bit sample is one word. A 24-bit or 32-bit sample is two words: the upper 16 bits come first, then the remaining bits left-aligned. With every stored word the block also records which channel the word came from. It flags a word that arrives while the buffer still holds an unread one, and it can raise an interrupt for a pending word and for that error.

Top module: `i2s_slave_rx`

## Requirements
- R1: After reset, data_o is 0 and rxne_o, side_o, ovr_o, irq_rx_o, irq_err_o and busy_o are all low.
- R2: With std_i = 00 (Philips), a slot starts at any word-select transition. The MSB of the slot is the bit sampled one bit clock after the first bit at the new level.
- R3: With std_i = 01 (MSB-justified), a slot starts at any word-select transition. The MSB is the first bit sampled at the new level.
- R4: With std_i = 10 (LSB-justified), the data bits fill the last bits of the slot. For 16-bit data in a 32-bit slot, capture starts at slot bit 16. For 24-bit data it starts at slot bit 8.
- R5: With std_i = 11 (PCM), only a rising word-select edge starts a slot, and the MSB follows one bit later. Every PCM word reports side 1.
- R6: dlen_i selects the data length: 00 is 16 bits, 01 is 24 bits, 10 or 11 is 32 bits. A 24-bit sample is delivered as data[23:8], then {data[7:0], 8'h00}. A 32-bit sample is delivered as data[31:16], then data[15:0].
- R7: chlen_i = 0 selects 16-bit slots, and the data length is then 16 bits whatever dlen_i holds. chlen_i = 1 selects 32-bit slots.
- R8: side_o takes the word-select level seen on the first bit of the slot that produced a stored word. It changes only when a word is stored.
- R9: Storing a word sets rxne_o. A pulse on rd_data_i clears it. irq_rx_o is rxne_ie_i AND rxne_o.
- R10: If a word completes while rxne_o is set and no read happens in the same cycle, ovr_o sets. The new word is dropped and data_o keeps the unread word. irq_err_o is err_ie_i AND ovr_o.
- R11: ovr_o clears only after a rd_data_i pulse followed by a later rd_stat_i pulse. A status read alone leaves it set.
- R12: busy_o stays low at all times, including while a stream is being received.
- R13: While en_i is low, no word is stored. Lowering en_i also discards any slot in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Bit clock from the external master |
| ws_i | input | 1 | Word select from the external master |
| sd_i | input | 1 | Serial data |
| en_i | input | 1 | Receiver enable |
| std_i | input | 2 | Framing: 00 Philips, 01 MSB-justified, 10 LSB-justified, 11 PCM |
| dlen_i | input | 2 | Data length: 00 16-bit, 01 24-bit, 1x 32-bit |
| chlen_i | input | 1 | Slot length: 0 16-bit, 1 32-bit |
| rxne_ie_i | input | 1 | Receive interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| rd_data_i | input | 1 | Data read strobe, one cycle |
| rd_stat_i | input | 1 | Status read strobe, one cycle |
| data_o | output | 16 | Receive buffer contents |
| rxne_o | output | 1 | Receive buffer holds an unread word |
| side_o | output | 1 | Channel side of the buffered word |
| ovr_o | output | 1 | Overrun flag |
| busy_o | output | 1 | Busy flag, constantly low |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
Any error in the slot counter or in the choice of start bit shows up as shifted bits in the very first word of a stream. The bench therefore checks whole words, across every framing and length case, in the order they arrive. A wrong bit-remaining count shows up as a missing or extra word at the halfway point of a 24-bit or 32-bit sample, or as a second word that ends up with the wrong alignment. A side register that updates at the wrong moment, or a stale overrun bookkeeping bit, shows up on side_o or ovr_o within a single read sequence. The overrun scenario steps through status and data reads one at a time and checks the flags after each step.

// File: rtl/i2s_slave_rx.sv
module i2s_slave_rx #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_i,
  input  logic        ws_i,
  input  logic        sd_i,
  input  logic        en_i,
  input  logic [1:0]  std_i,
  input  logic [1:0]  dlen_i,
  input  logic        chlen_i,
  input  logic        rxne_ie_i,
  input  logic        err_ie_i,
  input  logic        rd_data_i,
  input  logic        rd_stat_i,
  output logic [15:0] data_o,
  output logic        rxne_o,
  output logic        side_o,
  output logic        ovr_o,
  output logic        busy_o,
  output logic        irq_rx_o,
  output logic        irq_err_o
);
  localparam int WORD_W = 16;
  localparam int IDX_W  = 6;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [1:0] STD_MSB = 2'b01;
  localparam logic [1:0] STD_LSB = 2'b10;
  localparam logic [1:0] STD_PCM = 2'b11;

  logic [SYNC_DEPTH:0]   sck_q;
  logic [SYNC_DEPTH-1:0] ws_q, sd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      ws_q  <= '0;
      sd_q  <= '0;
    end else begin
      sck_q <= {sck_q[SYNC_DEPTH-1:0], sck_i};
      ws_q  <= {ws_q[SYNC_DEPTH-2:0], ws_i};
      sd_q  <= {sd_q[SYNC_DEPTH-2:0], sd_i};
    end

  wire ws_s     = ws_q[SYNC_DEPTH-1];
  wire sd_s     = sd_q[SYNC_DEPTH-1];
  wire bit_tick = en_i & sck_q[SYNC_DEPTH-1] & ~sck_q[SYNC_DEPTH];

  logic             have_prev, ws_prev, slot_ws, word_side;
  logic [IDX_W-1:0] idx, bits_left;
  logic [WORD_W-2:0] sreg;

  logic [IDX_W-1:0] clen, dbits, start_pos, idx_n, left_after;
  logic             slot_edge, start, shifting, push;
  logic [WORD_W-1:0] word_new, push_word;

  assign clen  = chlen_i ? IDX_W'(32) : IDX_W'(16);
  assign dbits = !chlen_i        ? IDX_W'(16) :
                 (dlen_i == 2'b00) ? IDX_W'(16) :
                 (dlen_i == 2'b01) ? IDX_W'(24) : IDX_W'(32);

  always_comb
    case (std_i)
      STD_MSB: start_pos = '0;
      STD_LSB: start_pos = clen - dbits;
      default: start_pos = IDX_W'(1);
    endcase

  assign slot_edge  = have_prev & ((std_i == STD_PCM) ? (ws_s & ~ws_prev) : (ws_s ^ ws_prev));
  assign idx_n      = slot_edge ? '0 : ((idx == IDX_MAX) ? idx : idx + 1'b1);
  assign start      = (idx_n == start_pos);
  assign shifting   = bit_tick & (start | (bits_left != '0));
  assign left_after = start ? dbits - 1'b1 : bits_left - 1'b1;
  assign word_new   = {sreg, sd_s};
  assign push       = shifting & ((left_after == '0) |
                      ((dbits > IDX_W'(16)) & (left_after == dbits - IDX_W'(16))));
  assign push_word  = ((left_after == '0) && (dbits == IDX_W'(24))) ?
                      {sreg[6:0], sd_s, 8'h00} : word_new;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      have_prev <= 1'b0;
      ws_prev   <= 1'b0;
      slot_ws   <= 1'b0;
      word_side <= 1'b0;
      idx       <= IDX_MAX;
      bits_left <= '0;
      sreg      <= '0;
    end else if (!en_i) begin
      have_prev <= 1'b0;
      idx       <= IDX_MAX;
      bits_left <= '0;
    end else if (bit_tick) begin
      have_prev <= 1'b1;
      ws_prev   <= ws_s;
      idx       <= idx_n;
      if (slot_edge) slot_ws <= ws_s;
      if (shifting) begin
        sreg      <= word_new[WORD_W-2:0];
        bits_left <= left_after;
      end
      if (start) word_side <= slot_edge ? ws_s : slot_ws;
    end

  logic ovr_seen;
  wire  accept = push & (~rxne_o | rd_data_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_o   <= '0;
      rxne_o   <= 1'b0;
      side_o   <= 1'b0;
      ovr_o    <= 1'b0;
      ovr_seen <= 1'b0;
    end else begin
      if (accept) begin
        data_o <= push_word;
        side_o <= word_side;
        rxne_o <= 1'b1;
      end else if (rd_data_i) begin
        rxne_o <= 1'b0;
      end
      if (push && rxne_o && !rd_data_i) begin
        ovr_o    <= 1'b1;
        ovr_seen <= 1'b0;
      end else if (rd_stat_i && ovr_seen) begin
        ovr_o    <= 1'b0;
        ovr_seen <= 1'b0;
      end else if (rd_data_i && ovr_o) begin
        ovr_seen <= 1'b1;
      end
    end

  assign busy_o    = 1'b0;
  assign irq_rx_o  = rxne_ie_i & rxne_o;
  assign irq_err_o = err_ie_i & ovr_o;

  AST_PUSH_SETS_RXNE: assert property (@(posedge clk) disable iff (!rst_n) push |=> rxne_o) else $error("push without rxne"); // R9
  AST_READ_CLEARS_RXNE: assert property (@(posedge clk) disable iff (!rst_n) (rd_data_i && !push) |=> !rxne_o) else $error("rxne not cleared"); // R9
  AST_OVR_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n) (rxne_o && !rd_data_i && push) |=> (ovr_o && $stable(data_o))) else $error("overrun handling"); // R10
  AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (ovr_o && !rd_stat_i) |=> ovr_o) else $error("overrun cleared early"); // R11
  AST_SIDE_ONLY_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n) !push |=> $stable(side_o)) else $error("side changed without word"); // R8
endmodule

// File: tb/test_i2s_slave_rx.sv
module test_i2s_slave_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0, en = 1'b0;
  logic [1:0] std_r = 2'b00, dlen_r = 2'b00;
  logic chlen_r = 1'b0, rxne_ie = 1'b0, err_ie = 1'b0;
  logic rd_data = 1'b0, rd_stat = 1'b0;
  logic [15:0] data_o;
  logic rxne_o, side_o, ovr_o, busy_o, irq_rx_o, irq_err_o;

  int n_cmp = 0, n_err = 0;
  bit done = 0;
  bit drain_on = 0;
  int rd_req = 0, rd_done = 0, st_req = 0, st_done = 0;
  logic [15:0] cap_w [32];
  logic        cap_s [32];
  int cap_n = 0;
  logic ws_a [80];
  logic sd_a [80];

  always #2.5ns clk = ~clk;

  i2s_slave_rx i_i2s_slave_rx (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd), .en_i(en),
    .std_i(std_r), .dlen_i(dlen_r), .chlen_i(chlen_r), .rxne_ie_i(rxne_ie),
    .err_ie_i(err_ie), .rd_data_i(rd_data), .rd_stat_i(rd_stat), .data_o(data_o),
    .rxne_o(rxne_o), .side_o(side_o), .ovr_o(ovr_o), .busy_o(busy_o),
    .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o));

  always @(negedge clk) begin
    rd_data <= 1'b0;
    rd_stat <= 1'b0;
    if (drain_on && rxne_o && !rd_data) begin
      if (cap_n < 32) begin
        cap_w[cap_n] = data_o;
        cap_s[cap_n] = side_o;
      end
      cap_n = cap_n + 1;
      rd_data <= 1'b1;
    end else if (rd_req != rd_done) begin
      rd_data <= 1'b1;
      rd_done = rd_done + 1;
    end else if (st_req != st_done) begin
      rd_stat <= 1'b1;
      st_done = st_done + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    sck = 1'b0; ws = w; sd = d;
    wait_cyc(4);
    sck = 1'b1;
    wait_cyc(4);
  endtask

  function automatic int eff_dbits(input logic [1:0] dl, input logic cl);
    if (!cl || dl == 2'b00) return 16;
    if (dl == 2'b01) return 24;
    return 32;
  endfunction

  task automatic run_stream(input logic [1:0] st, input logic [1:0] dl, input logic cl,
                            input logic enable, input logic [31:0] lv, input logic [31:0] rv);
    int clen, db, off, len;
    logic pcm;
    clen = cl ? 32 : 16;
    db   = eff_dbits(dl, cl);
    pcm  = (st == 2'b11);
    off  = (st == 2'b01) ? 0 : (st == 2'b10) ? clen - db : 1;
    en = 1'b0;
    wait_cyc(4);
    std_r = st; dlen_r = dl; chlen_r = cl;
    en = enable;
    wait_cyc(2);
    for (int i = 0; i < 80; i++) begin ws_a[i] = 1'b0; sd_a[i] = 1'b0; end
    ws_a[0] = !pcm; ws_a[1] = !pcm;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < clen; i++) begin
        ws_a[2 + s*clen + i] = pcm ? (i == 0) : (s == 1);
        if (i < db) sd_a[2 + s*clen + off + i] = (s == 0) ? lv[db-1-i] : rv[db-1-i];
      end
    len = 4 + 2*clen;
    for (int i = 0; i < len; i++) send_bit(ws_a[i], sd_a[i]);
    wait_cyc(40);
  endtask

  task automatic check_words(input string tag, input logic [1:0] st, input logic [1:0] dl,
                             input logic cl, input int base, input logic [31:0] lv, input logic [31:0] rv);
    logic [15:0] ew [4];
    logic        es [4];
    int ne, db;
    logic [31:0] v;
    db = eff_dbits(dl, cl);
    ne = 0;
    for (int s = 0; s < 2; s++) begin
      v = (s == 0) ? lv : rv;
      if (db == 16) begin
        ew[ne] = v[15:0]; es[ne] = (st == 2'b11) ? 1'b1 : (s == 1); ne++;
      end else begin
        ew[ne] = (db == 24) ? v[23:8] : v[31:16]; es[ne] = (st == 2'b11) ? 1'b1 : (s == 1); ne++;
        ew[ne] = (db == 24) ? {v[7:0], 8'h00} : v[15:0]; es[ne] = (st == 2'b11) ? 1'b1 : (s == 1); ne++;
      end
    end
    chk({tag, " word count"}, cap_n - base, ne);
    for (int k = 0; k < ne; k++) begin
      if (base + k < 32) begin
        chk($sformatf("%s word %0d data", tag, k), cap_w[base+k], ew[k]);
        chk($sformatf("%s word %0d side R8", tag, k), cap_s[base+k], es[k]);
      end
    end
  endtask

  task automatic t_reset;
    chk("R1 data", data_o, 0);
    chk("R1 flags", {rxne_o, side_o, ovr_o, irq_rx_o, irq_err_o, busy_o}, 0);
  endtask

  task automatic t_stream(input string tag, input logic [1:0] st, input logic [1:0] dl,
                          input logic cl, input logic [31:0] lv, input logic [31:0] rv);
    int base;
    drain_on = 1;
    base = cap_n;
    run_stream(st, dl, cl, 1'b1, lv, rv);
    check_words(tag, st, dl, cl, base, lv, rv);
    chk({tag, " R12 busy"}, busy_o, 0);
  endtask

  task automatic t_overrun;
    drain_on = 0;
    rxne_ie = 1'b0; err_ie = 1'b1;
    run_stream(2'b01, 2'b00, 1'b0, 1'b1, 32'h1111, 32'h2222);
    chk("R9 rxne set", rxne_o, 1);
    chk("R9 irq masked", irq_rx_o, 0);
    rxne_ie = 1'b1;
    wait_cyc(1);
    chk("R9 irq raised", irq_rx_o, 1);
    chk("R10 ovr set", ovr_o, 1);
    chk("R10 irq_err", irq_err_o, 1);
    chk("R10 data kept", data_o, 16'h1111);
    chk("R10 side kept R8", side_o, 0);
    st_req++; wait_cyc(4);
    chk("R11 status alone", ovr_o, 1);
    rd_req++; wait_cyc(4);
    chk("R9 rxne cleared", rxne_o, 0);
    chk("R9 irq cleared", irq_rx_o, 0);
    chk("R11 after data read", ovr_o, 1);
    st_req++; wait_cyc(4);
    chk("R11 ovr cleared", ovr_o, 0);
    chk("R10 irq_err cleared", irq_err_o, 0);
  endtask

  task automatic t_disabled;
    int base;
    drain_on = 1;
    base = cap_n;
    run_stream(2'b01, 2'b00, 1'b0, 1'b0, 32'h5A5A, 32'hA5A5);
    chk("R13 no words", cap_n - base, 0);
    chk("R13 rxne low", rxne_o, 0);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_stream("R2 philips 16/16", 2'b00, 2'b00, 1'b0, 32'hA5C3, 32'h3C5A);
    t_stream("R3 msb 16/32", 2'b01, 2'b00, 1'b1, 32'h1234, 32'hFEDC);
    t_stream("R4 lsb 16/32", 2'b10, 2'b00, 1'b1, 32'hBEEF, 32'h0F0F);
    t_stream("R4 R6 lsb 24/32", 2'b10, 2'b01, 1'b1, 32'hABCDEF, 32'h123456);
    t_stream("R6 philips 32/32", 2'b00, 2'b10, 1'b1, 32'hDEADBEEF, 32'h01234567);
    t_stream("R6 msb 24/32", 2'b01, 2'b01, 1'b1, 32'h89ABCD, 32'h765432);
    t_stream("R5 pcm 16/16", 2'b11, 2'b00, 1'b0, 32'h8001, 32'h7FFE);
    t_stream("R7 chlen16 dlen32", 2'b01, 2'b10, 1'b0, 32'hC0DE, 32'h0BAD);
    t_overrun();
    t_disabled();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule